// File: doc/BRIEF.md
# Double-Buffered Serial Data Buffers and Status Flags

This block sits between a host register port and the shift logic of a byte-wide serial interface. A transmit holding register feeds the transmit shifter, and the receive shifter feeds a receive holding register. Three status flags tell software when it may write the next byte, when transmission has finished, and when a received byte is waiting: transmit-empty, transmit-end and receive-full.

Hardware events from the serial side set the flags. Software clears each flag in one of two ways. It can read the flag as 1 from the status register and then write 0 to it, or it can access the matching data register: a transmit buffer write clears transmit-empty and transmit-end, and a receive buffer read clears receive-full. A set event that lands in the same cycle as a clear takes priority, so no event is lost. Bit shifting, serial clock generation and bus arbitration belong to other blocks; here they appear only as input strobes.

Top module: `sdb_flags`

## Requirements
- R1: After reset all three flags are 0, the status register reads 0x00, the receive buffer reads 0x00 and `tx_load` is 0.
- R2: Address map: 0 is status, 1 is the transmit buffer (write, and reads back), 2 is the receive buffer, and 3 reads 0. In status, bit 7 is transmit-empty, bit 6 is transmit-end and bit 5 is receive-full. Bits 4..0 always read 0, and writes to them are ignored.
- R3: `tx_load` asserts in a cycle only when the transmit buffer holds unsent data, `tx_shift_idle` is 1 and no transmit buffer write is present. `tx_load_data` then carries the buffer contents. After that edge transmit-empty is 1 and the buffer is no longer pending.
- R4: Transmit-empty also sets on each of `tx_mode_set`, `start_issued` and `slave_rx_to_tx`.
- R5: A transmit buffer write clears transmit-empty, unless a set event arrives in the same cycle.
- R6: With `sync_fmt`=0, transmit-end sets on `ninth_clk_rise` only while transmit-empty is 1. With `sync_fmt`=1 it sets on `frame_last_bit`. Any other combination leaves it at 0.
- R7: A transmit buffer write clears transmit-end.
- R8: `rx_xfer` sets receive-full and captures `rx_shift_data` into the receive buffer. Reading the receive buffer clears receive-full.
- R9: A status write with 0 in a flag bit clears that flag only if a status read has returned that flag as 1 since the flag last set. A write of 1 has no effect. A write of 0 without such a read also has no effect.
- R10: When a set event and a clear of the same flag occur in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Host read strobe; side effects on the clock edge |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| tx_shift_idle | input | 1 | Transmit shifter can accept a byte |
| tx_mode_set | input | 1 | Transmit-mode control bit was set |
| start_issued | input | 1 | Start or repeated start issued |
| slave_rx_to_tx | input | 1 | Slave switched from receive to transmit |
| sync_fmt | input | 1 | 1 = clocked synchronous format, 0 = bus format |
| ninth_clk_rise | input | 1 | Ninth serial clock rising edge |
| frame_last_bit | input | 1 | Last bit of a synchronous frame sent |
| rx_xfer | input | 1 | Receive shifter hands over a byte |
| rx_shift_data | input | 8 | Byte from the receive shifter |
| tx_load | output | 1 | Transmit buffer moves to shifter this cycle |
| tx_load_data | output | 8 | Byte handed to the transmit shifter |
| tx_empty | output | 1 | Transmit-empty flag |
| tx_end | output | 1 | Transmit-end flag |
| rx_full | output | 1 | Receive-full flag |

## Verification
The hardest state to reach is a flag whose clear permission has been armed by a status read and is then disturbed before software writes 0. That disturbance is either a fresh set event, which must withdraw the permission, or a set event in the very cycle of the clearing write, which must win. The bench reaches both by arranging an exact sequence of host transactions around serial strobes. It sweeps every combination of read-first and written bit value, every subset of the transmit-empty set strobes together with a buffer write, and every combination of format, prior transmit-empty state, ninth-clock strobe and last-bit strobe for transmit-end.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_TXB  = 2'd1;
  localparam logic [ADDR_W-1:0] A_RXB  = 2'd2;
  localparam int unsigned FLAG_N = 3;
  // flag index i lives at status bit DATA_W-1-i
  localparam int unsigned FI_TXE  = 0;
  localparam int unsigned FI_TEND = 1;
  localparam int unsigned FI_RXF  = 2;
endpackage

// File: rtl/sdb_flag_cell.sv
module sdb_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic side_clr,
  input  logic rd_stat,
  input  logic wr_stat,
  input  logic wr_bit,
  output logic flag_q
);
  logic arm_q, arm_d, flag_d, en;
  logic sw_clr;

  always_comb begin
    sw_clr = wr_stat & ~wr_bit & arm_q;
    en     = set_ev | side_clr | rd_stat | wr_stat;
    flag_d = flag_q;
    arm_d  = arm_q;
    if (set_ev) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (side_clr | sw_clr) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (rd_stat & flag_q) begin
      arm_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (en) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/sdb_txbuf.sv
module sdb_txbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shift_idle,
  output logic [DATA_W-1:0] buf_q,
  output logic              load
);
  logic pend_q, pend_d, en;

  always_comb begin
    load   = pend_q & shift_idle & ~wr;
    pend_d = wr ? 1'b1 : (load ? 1'b0 : pend_q);
    en     = wr | load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else if (wr) buf_q <= wdata;
  end
endmodule

// File: rtl/sdb_rxbuf.sv
module sdb_rxbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] buf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else if (capture) buf_q <= din;
  end
endmodule

// File: rtl/sdb_flags.sv
module sdb_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tx_shift_idle,
  input  logic              tx_mode_set,
  input  logic              start_issued,
  input  logic              slave_rx_to_tx,
  input  logic              sync_fmt,
  input  logic              ninth_clk_rise,
  input  logic              frame_last_bit,
  input  logic              rx_xfer,
  input  logic [DATA_W-1:0] rx_shift_data,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_load_data,
  output logic              tx_empty,
  output logic              tx_end,
  output logic              rx_full
);
  import sdb_pkg::*;

  logic rd_stat, wr_stat, wr_txb, rd_rxb;
  logic [FLAG_N-1:0] set_ev, side_clr, flag_q, wr_bits;
  logic [DATA_W-1:0] txb_q, rxb_q, stat_word;

  always_comb begin
    rd_stat = rd_en & (addr == A_STAT);
    wr_stat = wr_en & (addr == A_STAT);
    wr_txb  = wr_en & (addr == A_TXB);
    rd_rxb  = rd_en & (addr == A_RXB);
  end

  sdb_txbuf #(.DATA_W(DATA_W)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .wr(wr_txb), .wdata(wdata),
    .shift_idle(tx_shift_idle), .buf_q(txb_q), .load(tx_load)
  );
  assign tx_load_data = txb_q;

  sdb_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .capture(rx_xfer), .din(rx_shift_data),
    .buf_q(rxb_q)
  );

  always_comb begin
    set_ev[FI_TXE]    = tx_load | tx_mode_set | start_issued | slave_rx_to_tx;
    side_clr[FI_TXE]  = wr_txb;
    set_ev[FI_TEND]   = sync_fmt ? frame_last_bit : (ninth_clk_rise & flag_q[FI_TXE]);
    side_clr[FI_TEND] = wr_txb;
    set_ev[FI_RXF]    = rx_xfer;
    side_clr[FI_RXF]  = rd_rxb;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    assign wr_bits[i] = wdata[DATA_W-1-i];
    sdb_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_ev(set_ev[i]), .side_clr(side_clr[i]),
      .rd_stat(rd_stat), .wr_stat(wr_stat), .wr_bit(wr_bits[i]),
      .flag_q(flag_q[i])
    );
    assign stat_word[DATA_W-1-i] = flag_q[i];
  end
  assign stat_word[DATA_W-FLAG_N-1:0] = '0;

  always_comb begin
    case (addr)
      A_STAT:  rdata = stat_word;
      A_TXB:   rdata = txb_q;
      A_RXB:   rdata = rxb_q;
      default: rdata = '0;
    endcase
  end

  assign tx_empty = flag_q[FI_TXE];
  assign tx_end   = flag_q[FI_TEND];
  assign rx_full  = flag_q[FI_RXF];
endmodule

// File: rtl/sdb_flags_chk.sv
module sdb_flags_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              tx_shift_idle,
  input logic              tx_mode_set,
  input logic              start_issued,
  input logic              slave_rx_to_tx,
  input logic              sync_fmt,
  input logic              frame_last_bit,
  input logic              rx_xfer,
  input logic              tx_load,
  input logic              tx_empty,
  input logic              tx_end,
  input logic              rx_full
);
  p_load_needs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (tx_shift_idle && !(wr_en && addr == 2'd1)));

  p_load_sets_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_empty);

  p_mode_events_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode_set || start_issued || slave_rx_to_tx) |=> tx_empty);

  p_txwrite_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !tx_mode_set && !start_issued && !slave_rx_to_tx)
    |=> !tx_empty);

  p_sync_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_fmt && frame_last_bit) |=> tx_end);

  p_rx_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_xfer |=> rx_full);

  p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rdata[DATA_W-4:0] == '0));

  p_write_one_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[DATA_W-3] && !rx_xfer && !(rd_en && addr == 2'd2))
    |=> (rx_full == $past(rx_full)));
endmodule

bind sdb_flags sdb_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .tx_shift_idle(tx_shift_idle),
  .tx_mode_set(tx_mode_set), .start_issued(start_issued),
  .slave_rx_to_tx(slave_rx_to_tx), .sync_fmt(sync_fmt),
  .frame_last_bit(frame_last_bit), .rx_xfer(rx_xfer), .tx_load(tx_load),
  .tx_empty(tx_empty), .tx_end(tx_end), .rx_full(rx_full)
);

// File: tb/sdb_flags_tb.sv
`timescale 1ns/1ps
module sdb_flags_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic rd_en, wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, rx_shift_data, tx_load_data;
  logic tx_shift_idle, tx_mode_set, start_issued, slave_rx_to_tx;
  logic sync_fmt, ninth_clk_rise, frame_last_bit, rx_xfer;
  logic tx_load, tx_empty, tx_end, rx_full;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdb_flags u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_shift_idle(tx_shift_idle),
    .tx_mode_set(tx_mode_set), .start_issued(start_issued),
    .slave_rx_to_tx(slave_rx_to_tx), .sync_fmt(sync_fmt),
    .ninth_clk_rise(ninth_clk_rise), .frame_last_bit(frame_last_bit),
    .rx_xfer(rx_xfer), .rx_shift_data(rx_shift_data), .tx_load(tx_load),
    .tx_load_data(tx_load_data), .tx_empty(tx_empty), .tx_end(tx_end),
    .rx_full(rx_full)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic quiet();
    rd_en = 0; wr_en = 0; tx_mode_set = 0; start_issued = 0;
    slave_rx_to_tx = 0; ninth_clk_rise = 0; frame_last_bit = 0; rx_xfer = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    quiet();
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; cyc();
  endtask

  task automatic hrd(input logic [1:0] a);
    rd_en = 1; addr = a; cyc();
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a; #0.5; v = rdata;
  endtask

  logic [7:0] v;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    quiet(); addr = 0; wdata = 0; rx_shift_data = 0; tx_shift_idle = 0; sync_fmt = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    // R1 reset state
    peek(2'd0, v); chk("R1 status", v, 8'h00);
    peek(2'd2, v); chk("R1 rxbuf", v, 8'h00);
    chk("R1 tx_load", {7'd0, tx_load}, 8'h00);

    // R4/R5/R10 sweep over set strobes with a buffer write
    for (int c = 0; c < 16; c++) begin
      hwr(2'd1, 8'h11);            // clears empty (R5)
      chk("R5 empty cleared", {7'd0, tx_empty}, 8'h00);
      tx_mode_set = c[0]; start_issued = c[1]; slave_rx_to_tx = c[2];
      if (c[3]) begin wr_en = 1; addr = 2'd1; wdata = 8'h22; end
      cyc();
      chk("R4 R10 empty after strobes", {7'd0, tx_empty}, {7'd0, |c[2:0]});
    end

    // R6/R7 sweep
    for (int c = 0; c < 8; c++) begin
      logic exp_e;
      hwr(2'd1, 8'h33);
      chk("R7 end cleared", {7'd0, tx_end}, 8'h00);
      if (c[1]) begin start_issued = 1; cyc(); end
      sync_fmt = c[0];
      for (int s = 0; s < 4; s++) begin
        ninth_clk_rise = s[0]; frame_last_bit = s[1];
        cyc();
        exp_e = c[0] ? s[1] : (s[0] & c[1]);
        chk("R6 end flag", {7'd0, tx_end}, {7'd0, exp_e});
        if (exp_e) begin
          hwr(2'd1, 8'h44);
          chk("R7 end cleared by write", {7'd0, tx_end}, 8'h00);
          if (c[1]) begin start_issued = 1; cyc(); end
        end
      end
    end
    sync_fmt = 0;

    // R3 transfer
    hwr(2'd1, 8'hA5);
    tx_shift_idle = 1; wr_en = 1; addr = 2'd1; wdata = 8'h3C;
    #0.5 chk("R3 no load during write", {7'd0, tx_load}, 8'h00);
    cyc();
    chk("R5 empty after write", {7'd0, tx_empty}, 8'h00);
    #0.5 chk("R3 load asserted", {7'd0, tx_load}, 8'h01);
    chk("R3 load data", tx_load_data, 8'h3C);
    cyc();
    chk("R3 empty after load", {7'd0, tx_empty}, 8'h01);
    chk("R3 load once", {7'd0, tx_load}, 8'h00);
    peek(2'd1, v); chk("R2 txbuf readback", v, 8'h3C);
    tx_shift_idle = 0;

    // R8 receive
    hrd(2'd2);
    rx_xfer = 1; rx_shift_data = 8'h5A; cyc();
    chk("R8 full set", {7'd0, rx_full}, 8'h01);
    peek(2'd2, v); chk("R8 data", v, 8'h5A);
    hrd(2'd2);
    chk("R8 full cleared by read", {7'd0, rx_full}, 8'h00);

    // R2 layout and low bits
    rx_xfer = 1; rx_shift_data = 8'h77; cyc();
    hwr(2'd1, 8'h00); start_issued = 1; cyc();   // empty=1,end=0,full=1
    hwr(2'd0, 8'hFF);
    peek(2'd0, v); chk("R2 status layout", v, 8'hA0);
    peek(2'd3, v); chk("R2 addr3 zero", v, 8'h00);

    // R9 sweep on receive-full
    for (int c = 0; c < 4; c++) begin
      hrd(2'd2);
      rx_xfer = 1; cyc();
      if (c[0]) hrd(2'd0);
      hwr(2'd0, {2'b00, c[1], 5'b11111} | 8'hC0);
      chk("R9 write0 rule", {7'd0, rx_full}, {7'd0, !(c[0] && !c[1])});
    end
    // R9 write0 on transmit-empty after read
    start_issued = 1; cyc(); hrd(2'd0); hwr(2'd0, 8'h20);
    chk("R9 empty cleared by read-write0", {7'd0, tx_empty}, 8'h00);
    // R9 new set withdraws permission
    hrd(2'd2); rx_xfer = 1; cyc(); hrd(2'd0);
    rx_xfer = 1; cyc();
    hwr(2'd0, 8'h00);
    chk("R9 reset arm on set", {7'd0, rx_full}, 8'h01);
    // R10 set vs clear same cycle
    hrd(2'd0);
    rx_xfer = 1; wr_en = 1; addr = 2'd0; wdata = 8'h00; cyc();
    chk("R10 set beats write0", {7'd0, rx_full}, 8'h01);
    rx_xfer = 1; rd_en = 1; addr = 2'd2; cyc();
    chk("R10 set beats rx read", {7'd0, rx_full}, 8'h01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule